// File: doc/BRIEF.md
# Constant-Weight Key Encoder

The encoder turns a short binary search key into a codeword of 2N bits in which exactly N bits are ones. It works through the combinatorial number system. It is meant to sit in front of a match array whose rows each store one balanced pattern, so that an encoded key can drive the search lines directly. A full word is compared at once, rather than one bit against a pair of cells.

Encoding is iterative. The encoder walks a weight counter from N down to 1, and each clock cycle places one more one-bit. For the current weight r, it picks the highest bit position c in the range 0 to 2N-1 whose binomial coefficient C(c, r) is no larger than the remaining key. It sets that bit and subtracts that coefficient from the remainder. The coefficients are constants generated at elaboration into a small table with N rows, one row per weight, so the datapath holds only comparators and one subtractor.

A request is taken only while the encoder is idle. The finished codeword is announced by a single-cycle done pulse, and it stays on the output until the next codeword replaces it.

Top module: `cwe_encoder`

## Requirements
- R1: With parameter N, the key port is floor(log2(C(2N,N))) bits wide and the codeword is 2N bits wide. For the default N=4, these widths are 6 and 8.
- R2: While reset is high, and in the first cycle after reset, done_o is 0 and code_o is all zeros.
- R3: A key is captured at a rising edge where start_i is high and the encoder is idle. done_o is then high for exactly one cycle, and it rises at the N-th rising edge after the capture edge.
- R4: Every finished codeword contains exactly N ones.
- R5: The codeword is built over steps with weight r = N, N-1, ..., 1. At each step, bit c (bit 0 is the LSB) is set, where c is the largest position in 0..2N-1 with C(c,r) no larger than the remaining key, and C(c,r) is then subtracted from the key. For N=4, key 60 gives 8'b11001100.
- R6: Key 0 gives the N lowest bits set. For N=4, this is 8'b00001111.
- R7: All 2^w keys produce pairwise distinct codewords.
- R8: A start_i request at an edge where the encoder is busy is ignored. It changes neither the codeword under construction nor the number of done pulses.
- R9: code_o changes only at the edge that raises done_o, and it holds its value at all other times.
- R10: A start_i that is high in the cycle where done_o is high is accepted, so keys can be encoded back to back with no idle cycle.
- R11: While encoding, exactly one new one-bit is added to the partial codeword on every clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to encode key_i; taken only when idle |
| key_i | input | w (6 at N=4) | Binary key, unsigned |
| done_o | output | 1 | One-cycle pulse marking a new codeword on code_o |
| code_o | output | 2N (8 at N=4) | Last finished constant-weight codeword |

## Verification
Two events can fall in the same cycle. One is completion of a codeword, which shows as done_o high. The other is acceptance of the next request. The bench provokes this by raising start_i in the very cycle it sees done_o, for every key in a full sweep. A FIFO scoreboard then has to receive each expected codeword in order with nothing lost or repeated. It also checks that the pulsed codeword is not disturbed by the overlapping start. A second overlap, a request arriving while a key is still being encoded, is injected with a different key on every third sweep item and judged by the same scoreboard.

// File: rtl/cwe_pkg.sv
package cwe_pkg;

    // Binomial coefficient C(n, r); zero when r exceeds n.
    function automatic longint unsigned binom(input int unsigned n, input int unsigned r);
        longint unsigned acc;
        acc = 1;
        if (r > n) return 0;
        for (int unsigned i = 0; i < r; i++) begin
            acc = acc * longint'(n - i) / longint'(i + 1);
        end
        return acc;
    endfunction

    // Key width: floor(log2(C(2n, n))).
    function automatic int unsigned key_bits(input int unsigned n);
        longint unsigned total;
        int unsigned     w;
        total = binom(2 * n, n);
        w     = 0;
        for (int unsigned i = 1; i < 62; i++) begin
            if ((longint'(1) << i) <= total) w = i;
        end
        return w;
    endfunction

endpackage

// File: rtl/cwe_coef_rom.sv
module cwe_coef_rom #(
    parameter int N   = 4,
    parameter int CW  = 2 * N,
    parameter int CFW = 7,
    parameter int SW  = 3
) (
    input  logic [SW-1:0]           row_i,
    output logic [CW-1:0][CFW-1:0]  coef_o
);
    logic [N-1:0][CW-1:0][CFW-1:0] tbl;

    for (genvar r = 1; r <= N; r++) begin : g_row
        for (genvar c = 0; c < CW; c++) begin : g_col
            assign tbl[r-1][c] = CFW'(cwe_pkg::binom(c, r));
        end
    end

    always_comb begin
        coef_o = '0;
        for (int r = 1; r <= N; r++) begin
            if (row_i == SW'(r)) coef_o = tbl[r-1];
        end
    end
endmodule

// File: rtl/cwe_pos_search.sv
module cwe_pos_search #(
    parameter int CW  = 8,
    parameter int KW  = 6,
    parameter int CFW = KW + 1,
    parameter int PW  = $clog2(CW)
) (
    input  logic [KW-1:0]          rem_i,
    input  logic [CW-1:0][CFW-1:0] coef_i,
    output logic [PW-1:0]          pos_o,
    output logic [KW-1:0]          sub_o
);
    // Last match in ascending order wins: highest position fitting the remainder.
    always_comb begin
        pos_o = '0;
        sub_o = '0;
        for (int c = 0; c < CW; c++) begin
            if (coef_i[c] <= {1'b0, rem_i}) begin
                pos_o = PW'(c);
                sub_o = coef_i[c][KW-1:0];
            end
        end
    end
endmodule

// File: rtl/cwe_encoder.sv
module cwe_encoder #(
    parameter int N = 4,
    localparam int CW  = 2 * N,
    localparam int KW  = cwe_pkg::key_bits(N),
    localparam int CFW = KW + 1,
    localparam int SW  = $clog2(N + 1),
    localparam int PW  = (CW > 2) ? $clog2(CW) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [KW-1:0] key_i,
    output logic          done_o,
    output logic [CW-1:0] code_o
);
    typedef struct packed {
        logic          busy;
        logic          done;
        logic [SW-1:0] weight;
        logic [KW-1:0] rem;
        logic [CW-1:0] part;
        logic [CW-1:0] word;
    } enc_st_t;

    enc_st_t st_d, st_q;

    logic [CW-1:0][CFW-1:0] coef;
    logic [PW-1:0]          pos;
    logic [KW-1:0]          sub;
    logic [CW-1:0]          pick;
    logic                   busy_w;
    logic [CW-1:0]          part_w;

    cwe_coef_rom #(.N(N), .CW(CW), .CFW(CFW), .SW(SW)) u_rom (
        .row_i  (st_q.weight),
        .coef_o (coef)
    );

    cwe_pos_search #(.CW(CW), .KW(KW), .CFW(CFW), .PW(PW)) u_search (
        .rem_i  (st_q.rem),
        .coef_i (coef),
        .pos_o  (pos),
        .sub_o  (sub)
    );

    assign pick = CW'(1) << pos;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy   = 1'b1;
                st_d.weight = SW'(N);
                st_d.rem    = key_i;
                st_d.part   = '0;
            end
        end else begin
            st_d.part = st_q.part | pick;
            st_d.rem  = st_q.rem - sub;
            if (st_q.weight == SW'(1)) begin
                st_d.busy   = 1'b0;
                st_d.done   = 1'b1;
                st_d.weight = '0;
                st_d.word   = st_q.part | pick;
            end else begin
                st_d.weight = st_q.weight - SW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign done_o = st_q.done;
    assign code_o = st_q.word;
    assign busy_w = st_q.busy;
    assign part_w = st_q.part;
endmodule

// File: rtl/cwe_encoder_chk.sv
module cwe_encoder_chk #(
    parameter int N  = 4,
    parameter int CW = 2 * N
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          done_o,
    input logic [CW-1:0] code_o,
    input logic          busy,
    input logic [CW-1:0] part
);
    logic run_q;
    int   cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= 0;
        end else if (start_i && !busy) begin
            run_q <= 1'b1;
            cnt_q <= 0;
        end else if (done_o) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q + 1;
        end
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (run_q && cnt_q == N)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R3
    AST_WEIGHT_N: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($countones(code_o) == N)); // R4
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(code_o)); // R9
    AST_BIT_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($countones(part) == $countones($past(part)) + 1)); // R11
endmodule

bind cwe_encoder cwe_encoder_chk #(.N(N), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .done_o  (done_o),
    .code_o  (code_o),
    .busy    (busy_w),
    .part    (part_w)
);

// File: tb/tb_cwe_encoder.sv
module tb_cwe_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int CW = 2 * N;

    function automatic longint tb_choose(input int n, input int r);
        longint v;
        if (r < 0 || r > n) return 0;
        v = 1;
        for (int i = 1; i <= r; i++) v = v * (n - r + i) / i;
        return v;
    endfunction

    function automatic int tb_keyw(input int n);
        longint t;
        int w;
        t = tb_choose(2 * n, n);
        w = 0;
        while ((longint'(1) << (w + 1)) <= t) w++;
        return w;
    endfunction

    localparam int KW = tb_keyw(N);

    function automatic logic [CW-1:0] ref_code(input int k);
        logic [CW-1:0] cw;
        longint rem;
        int c;
        cw  = '0;
        rem = k;
        for (int r = N; r >= 1; r--) begin
            c = CW - 1;
            while (c > 0 && tb_choose(c, r) > rem) c--;
            cw[c] = 1'b1;
            rem   = rem - tb_choose(c, r);
        end
        return cw;
    endfunction

    typedef struct {
        int            key;
        logic [CW-1:0] exp;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [KW-1:0] key_i = '0;
    logic          done_o;
    logic [CW-1:0] code_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    n_done   = 0;
    int    n_unique = 0;
    bit    mon_on   = 0;
    bit    finished = 0;
    item_t sb_q[$];
    logic [CW-1:0] last_code = '0;
    bit    seen [0:(1<<CW)-1];

    always #(CLK_PERIOD/2) clk = ~clk;

    cwe_encoder #(.N(N)) dut (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .key_i   (key_i),
        .done_o  (done_o),
        .code_o  (code_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Monitor: pops the scoreboard on each done pulse, watches hold otherwise.
    always @(negedge clk) begin
        if (mon_on) begin
            if (done_o) begin
                item_t it;
                n_done++;
                if (sb_q.size() == 0) begin
                    check(0, "R8 unexpected done", code_o, 0);
                end else begin
                    it = sb_q.pop_front();
                    check(code_o == it.exp, "R5 codeword", code_o, it.exp);
                    check($countones(code_o) == N, "R4 weight", $countones(code_o), N);
                    if (N == 4 && it.key == 60)
                        check(code_o == 8'b11001100, "R5 key 60", code_o, 8'hCC);
                    if (it.key == 0)
                        check(code_o == CW'((1 << N) - 1), "R6 key zero", code_o, (1 << N) - 1);
                    check(!seen[code_o], "R7 distinct", code_o, 0);
                    if (!seen[code_o]) n_unique++;
                    seen[code_o] = 1'b1;
                end
            end else begin
                check(code_o == last_code, "R9 hold", code_o, last_code);
            end
            last_code = code_o;
        end
    end

    // Driver
    initial begin
        for (int i = 0; i < (1 << CW); i++) seen[i] = 1'b0;
        repeat (3) @(negedge clk);
        check(done_o == 1'b0, "R2 done in reset", done_o, 0);
        check(code_o == '0, "R2 code in reset", code_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(done_o == 1'b0, "R2 done after reset", done_o, 0);
        check(code_o == '0, "R2 code after reset", code_o, 0);
        check($bits(key_i) == KW && KW == 6, "R1 key width", $bits(key_i), 6);
        check($bits(code_o) == CW && CW == 8, "R1 code width", $bits(code_o), 8);
        mon_on = 1;

        for (int k = 0; k < (1 << KW); k++) begin
            item_t it;
            it.key  = k;
            it.exp  = ref_code(k);
            // R10: on back-to-back items this start lands in the done cycle.
            start_i = 1'b1;
            key_i   = KW'(k);
            sb_q.push_back(it);
            @(negedge clk);
            start_i = 1'b0;
            if (k % 3 == 1) begin
                // R8: request while busy, with a different key.
                start_i = 1'b1;
                key_i   = KW'(~k);
                @(negedge clk);
                start_i = 1'b0;
            end
            while (!done_o) @(negedge clk);
            if (k % 4 == 0) repeat (3) @(negedge clk);
        end
        repeat (N + 4) @(negedge clk);
        check(sb_q.size() == 0, "R10 all results delivered", sb_q.size(), 0);
        check(n_done == (1 << KW), "R8 done count", n_done, 1 << KW);
        check(n_unique == (1 << KW), "R7 unique count", n_unique, 1 << KW);
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", n_done, 1 << KW);
        finish_run();
    end
endmodule